// File: doc/BRIEF.md
# Cascaded 32-bit Counter with Cross-Linked Capture

This block pairs two 16-bit counter channels. The low channel can count up on a synchronous count enable. It can instead decode a two-phase quadrature pair. The high channel can be chained to the low one: it steps up when the low counter wraps upward and steps down when it wraps downward. The pair then reads as one coherent 32-bit count. If the high channel is put into its own quadrature mode, the chain is broken and each channel follows its own phase pair.

Each channel has two capture registers, A and B. Four capture pins drive them, ordered high-A, high-B, low-A, low-B. A per-register link bit ORs the register's own pin with the matching pin of the other channel, so one pin can snapshot both halves in the same cycle. Edges are found on the combined level. While one pin is held high, a change on its partner is therefore invisible. All pins pass through a synchronizer before any decoding, and the edge polarity is selectable.

Top module: `casc_ctr32`

## Requirements
- R1: With `lo_phase_mode`=0, the low counter increments by one on every clock where `cnt_en` is 1, and it wraps from 0xFFFF to 0x0000.
- R2: When chained (`alt_casc_mode`=0, `hi_clk_carry`=1, `hi_phase_mode`=0), the high counter increments on the same clock edge on which the low counter wraps upward. In plain low mode the high counter never decrements.
- R3: With `lo_phase_mode`=1, the low counter decodes the state {A,B} of `lo_ph_a`/`lo_ph_b`. The sequence 00→10→11→01→00 counts up one per step, and the reverse order counts down. A step where both phases change at once is ignored. A phase change takes effect on the third rising clock edge after it.
- R4: When chained with the low channel in quadrature mode, a low wrap from 0x0000 to 0xFFFF decrements the high counter on the same edge.
- R5: With `hi_phase_mode`=1, the high counter decodes `hi_ph_a`/`hi_ph_b` with the encoding of R3 and ignores low wraps. With `hi_phase_mode`=0 and either `alt_casc_mode`=1 or `hi_clk_carry`=0, the high counter holds.
- R6: The bits of `link_en` and `cap_pin` are ordered 0=high-A, 1=high-B, 2=low-A, 3=low-B. With a link bit at 0, only the register's own pin triggers it, and its partner pin (index XOR 2) has no effect.
- R7: With a link bit at 1, the trigger is the OR of the own and partner pins. While either pin is high, edges on the other produce no capture.
- R8: `edge_sel` selects 0=none, 1=rising, 2=falling, 3=both. On a capture, the register takes its own channel's counter value (indices 0–1: high half; 2–3: low half), and the matching `cap_strobe` bit is high for one cycle.
- R9: Registers that fire in the same cycle latch the two counter halves from that same cycle, forming a consistent 32-bit snapshot.
- R10: Reset clears both counters, all capture registers and all strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Low channel count enable in plain mode |
| lo_phase_mode | input | 1 | Low channel quadrature mode |
| hi_phase_mode | input | 1 | High channel quadrature mode (breaks chain) |
| hi_clk_carry | input | 1 | High channel clocked by low wrap events |
| alt_casc_mode | input | 1 | 1 disables the wrap-driven chain |
| lo_ph_a | input | 1 | Low channel phase A |
| lo_ph_b | input | 1 | Low channel phase B |
| hi_ph_a | input | 1 | High channel phase A |
| hi_ph_b | input | 1 | High channel phase B |
| cap_pin | input | 4 | Capture pins (hiA, hiB, loA, loB) |
| link_en | input | 4 | Per-register partner-pin OR enable |
| edge_sel | input | 2 | Capture edge polarity |
| count_out | output | 2*CW (32) | {high, low} counter value |
| cap_hi_a | output | CW (16) | High channel capture A |
| cap_hi_b | output | CW (16) | High channel capture B |
| cap_lo_a | output | CW (16) | Low channel capture A |
| cap_lo_b | output | CW (16) | Low channel capture B |
| cap_strobe | output | 4 | One-cycle capture pulses |

## Verification
The wrap and hold properties assume that the mode inputs are sampled on the same edge as `cnt_en`, and that they describe the path in force for that edge. The stimulus therefore changes mode bits only at falling edges, while counts and pins are idle. The capture-value properties assume that `cap_strobe` and the register load come from one edge. The stimulus holds each pin level for several cycles, so that the synchronizer never sees a level narrower than a clock period.

// File: rtl/casc_pkg.sv
package casc_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_sel_e;

   localparam int N_CAP = 4;
endpackage

// File: rtl/casc_sync.sv
module casc_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/casc_quad_dec.sv
module casc_quad_dec (
   input  logic clk,
   input  logic rst_n,
   input  logic ph_a,
   input  logic ph_b,
   output logic step_up,
   output logic step_dn
);
   logic [1:0] prev_q;
   logic [1:0] cur;
   logic [1:0] diff;
   logic       single;
   logic       fwd;

   assign cur    = {ph_a, ph_b};
   assign diff   = cur ^ prev_q;
   assign single = (diff == 2'b01) || (diff == 2'b10);
   assign fwd    = cur[1] ^ prev_q[0];

   assign step_up = single & fwd;
   assign step_dn = single & ~fwd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 2'b00;
      else        prev_q <= cur;
   end
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          carry,
   output logic          borrow
);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   assign carry  = inc & (cnt == TOP);
   assign borrow = dec & (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
      else if (dec) cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/casc_capture.sv
module casc_capture
   import casc_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          own_pin,
   input  logic          partner_pin,
   input  logic          link,
   input  logic [1:0]    edge_sel,
   input  logic [CW-1:0] value,
   output logic [CW-1:0] cap_val,
   output logic          strobe
);
   logic comb_lvl;
   logic prev_q;
   logic rise;
   logic fall;
   logic hit;

   assign comb_lvl = own_pin | (link & partner_pin);
   assign rise     = comb_lvl & ~prev_q;
   assign fall     = ~comb_lvl & prev_q;
   assign hit      = (rise && (edge_sel == EDGE_RISE || edge_sel == EDGE_BOTH)) ||
                     (fall && (edge_sel == EDGE_FALL || edge_sel == EDGE_BOTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         cap_val <= '0;
         strobe  <= 1'b0;
      end else begin
         prev_q <= comb_lvl;
         strobe <= hit;
         if (hit) cap_val <= value;
      end
   end
endmodule

// File: rtl/casc_ctr32.sv
module casc_ctr32
   import casc_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cnt_en,
   input  logic            lo_phase_mode,
   input  logic            hi_phase_mode,
   input  logic            hi_clk_carry,
   input  logic            alt_casc_mode,
   input  logic            lo_ph_a,
   input  logic            lo_ph_b,
   input  logic            hi_ph_a,
   input  logic            hi_ph_b,
   input  logic [3:0]      cap_pin,
   input  logic [3:0]      link_en,
   input  logic [1:0]      edge_sel,
   output logic [2*CW-1:0] count_out,
   output logic [CW-1:0]   cap_hi_a,
   output logic [CW-1:0]   cap_hi_b,
   output logic [CW-1:0]   cap_lo_a,
   output logic [CW-1:0]   cap_lo_b,
   output logic [3:0]      cap_strobe
);
   localparam int NSYNC = N_CAP + 4;

   if (CW < 2) begin : g_bad_cw
      $error("casc_ctr32: CW must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("casc_ctr32: SYNC_STAGES must be at least 2");
   end

   logic [NSYNC-1:0] raw_in;
   logic [NSYNC-1:0] syn;
   logic [N_CAP-1:0] pin_s;

   assign raw_in = {cap_pin, hi_ph_b, hi_ph_a, lo_ph_b, lo_ph_a};

   casc_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in),
      .dout (syn)
   );

   assign pin_s = syn[NSYNC-1:4];

   logic lo_qup, lo_qdn, hi_qup, hi_qdn;

   casc_quad_dec u_lo_dec (
      .clk(clk), .rst_n(rst_n), .ph_a(syn[0]), .ph_b(syn[1]),
      .step_up(lo_qup), .step_dn(lo_qdn)
   );

   casc_quad_dec u_hi_dec (
      .clk(clk), .rst_n(rst_n), .ph_a(syn[2]), .ph_b(syn[3]),
      .step_up(hi_qup), .step_dn(hi_qdn)
   );

   logic lo_inc, lo_dec, hi_inc, hi_dec;
   logic lo_carry, lo_borrow, hi_carry_unused, hi_borrow_unused;
   logic chained;
   logic [CW-1:0] lo_cnt, hi_cnt;

   assign chained = ~alt_casc_mode & hi_clk_carry;
   assign lo_inc  = lo_phase_mode ? lo_qup : cnt_en;
   assign lo_dec  = lo_phase_mode & lo_qdn;

   always_comb begin
      if (hi_phase_mode) begin
         hi_inc = hi_qup;
         hi_dec = hi_qdn;
      end else if (chained) begin
         hi_inc = lo_carry;
         hi_dec = lo_borrow;
      end else begin
         hi_inc = 1'b0;
         hi_dec = 1'b0;
      end
   end

   casc_counter #(.CW(CW)) u_lo_cnt (
      .clk(clk), .rst_n(rst_n), .inc(lo_inc), .dec(lo_dec),
      .cnt(lo_cnt), .carry(lo_carry), .borrow(lo_borrow)
   );

   casc_counter #(.CW(CW)) u_hi_cnt (
      .clk(clk), .rst_n(rst_n), .inc(hi_inc), .dec(hi_dec),
      .cnt(hi_cnt), .carry(hi_carry_unused), .borrow(hi_borrow_unused)
   );

   assign count_out = {hi_cnt, lo_cnt};

   logic [CW-1:0] cap_q [N_CAP];

   for (genvar gi = 0; gi < N_CAP; gi++) begin : g_cap
      localparam int PARTNER = gi ^ 2;
      logic [CW-1:0] src;
      if (gi < 2) begin : g_hi
         assign src = hi_cnt;
      end else begin : g_lo
         assign src = lo_cnt;
      end
      casc_capture #(.CW(CW)) u_cap (
         .clk        (clk),
         .rst_n      (rst_n),
         .own_pin    (pin_s[gi]),
         .partner_pin(pin_s[PARTNER]),
         .link       (link_en[gi]),
         .edge_sel   (edge_sel),
         .value      (src),
         .cap_val    (cap_q[gi]),
         .strobe     (cap_strobe[gi])
      );
   end

   assign cap_hi_a = cap_q[0];
   assign cap_hi_b = cap_q[1];
   assign cap_lo_a = cap_q[2];
   assign cap_lo_b = cap_q[3];
endmodule

// File: rtl/casc_ctr32_chk.sv
module casc_ctr32_chk #(
   parameter int CW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cnt_en,
   input logic            lo_phase_mode,
   input logic            hi_phase_mode,
   input logic            hi_clk_carry,
   input logic            alt_casc_mode,
   input logic [2*CW-1:0] count_out,
   input logic [CW-1:0]   cap_hi_a,
   input logic [CW-1:0]   cap_lo_a,
   input logic [3:0]      cap_strobe
);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   logic [CW-1:0] hi_v, lo_v;
   logic          chain_plain;

   assign hi_v = count_out[2*CW-1:CW];
   assign lo_v = count_out[CW-1:0];
   assign chain_plain = !alt_casc_mode && hi_clk_carry && !hi_phase_mode && !lo_phase_mode;

   AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!lo_phase_mode && cnt_en && lo_v == TOP) |=> (lo_v == '0)); // R1

   AST_CARRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_plain && cnt_en && lo_v == TOP) |=> (hi_v == CW'($past(hi_v) + 1'b1))); // R2

   AST_NO_DOWN_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      chain_plain |=> (hi_v == $past(hi_v) || hi_v == CW'($past(hi_v) + 1'b1))); // R2

   AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!hi_phase_mode && (alt_casc_mode || !hi_clk_carry)) |=> $stable(hi_v)); // R5

   AST_CAP_HI_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe[0] |-> (cap_hi_a == $past(hi_v))); // R8

   AST_CAP_LO_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_strobe[2] |-> (cap_lo_a == $past(lo_v))); // R9
endmodule

bind casc_ctr32 casc_ctr32_chk #(.CW(CW)) u_casc_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cnt_en       (cnt_en),
   .lo_phase_mode(lo_phase_mode),
   .hi_phase_mode(hi_phase_mode),
   .hi_clk_carry (hi_clk_carry),
   .alt_casc_mode(alt_casc_mode),
   .count_out    (count_out),
   .cap_hi_a     (cap_hi_a),
   .cap_lo_a     (cap_lo_a),
   .cap_strobe   (cap_strobe)
);

// File: tb/casc_ctr32_bench.sv
module casc_ctr32_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        lo_phase_mode = 1'b0;
   logic        hi_phase_mode = 1'b0;
   logic        hi_clk_carry = 1'b1;
   logic        alt_casc_mode = 1'b0;
   logic        lo_ph_a = 1'b0, lo_ph_b = 1'b0;
   logic        hi_ph_a = 1'b0, hi_ph_b = 1'b0;
   logic [3:0]  cap_pin = 4'b0;
   logic [3:0]  link_en = 4'b0;
   logic [1:0]  edge_sel = 2'd1;
   logic [31:0] count_out;
   logic [15:0] cap_hi_a, cap_hi_b, cap_lo_a, cap_lo_b;
   logic [3:0]  cap_strobe;

   int n_chk = 0;
   int n_bad = 0;
   int strb_cnt [4] = '{0, 0, 0, 0};
   int coin_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   casc_ctr32 u_casc_ctr32 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
      .lo_phase_mode(lo_phase_mode), .hi_phase_mode(hi_phase_mode),
      .hi_clk_carry(hi_clk_carry), .alt_casc_mode(alt_casc_mode),
      .lo_ph_a(lo_ph_a), .lo_ph_b(lo_ph_b), .hi_ph_a(hi_ph_a), .hi_ph_b(hi_ph_b),
      .cap_pin(cap_pin), .link_en(link_en), .edge_sel(edge_sel),
      .count_out(count_out), .cap_hi_a(cap_hi_a), .cap_hi_b(cap_hi_b),
      .cap_lo_a(cap_lo_a), .cap_lo_b(cap_lo_b), .cap_strobe(cap_strobe)
   );

   always @(negedge clk) begin
      for (int k = 0; k < 4; k++) if (cap_strobe[k]) strb_cnt[k]++;
      if (cap_strobe[0] && cap_strobe[2]) coin_cnt++;
   end

   // quadrature table: phase state {A,B} applied to the low pair, expected {hi,lo}
   localparam logic [1:0] VPH [14] = '{
      2'b10, 2'b11, 2'b01, 2'b00, 2'b01, 2'b11, 2'b10,
      2'b00, 2'b01, 2'b00, 2'b11, 2'b10, 2'b00, 2'b10 };
   localparam logic [31:0] VEXP [14] = '{
      32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0004,
      32'h0000_0003, 32'h0000_0002, 32'h0000_0001, 32'h0000_0000,
      32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF,
      32'hFFFF_FFFE, 32'hFFFF_FFFF };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_en(input int n);
      cnt_en = 1'b1;
      wait_n(n);
      cnt_en = 1'b0;
      wait_n(2);
   endtask

   task automatic set_pin(input int idx, input logic v);
      cap_pin[idx] = v;
      wait_n(6);
   endtask

   initial begin
      wait_n(3);
      check("R10 reset count", count_out, 32'h0);
      check("R10 reset caps", {cap_hi_a, cap_lo_b}, 32'h0);
      check("R10 reset strobe", {28'h0, cap_strobe}, 32'h0);
      rst_n = 1'b1;
      wait_n(2);

      // R3 / R4 quadrature walk, chained
      lo_phase_mode = 1'b1;
      for (int i = 0; i < 14; i++) begin
         {lo_ph_a, lo_ph_b} = VPH[i];
         wait_n(5);
         check((i == 8 || i == 11) ? "R4 borrow" : "R3 quad step", count_out, VEXP[i]);
      end

      // R1 / R2 plain counting with carry into the high half
      lo_phase_mode = 1'b0;
      wait_n(1);
      pulse_en(1);
      check("R2 carry wrap", count_out, 32'h0000_0000);
      pulse_en(3);
      check("R1 plain count", count_out, 32'h0000_0003);

      // R5 chain broken by alt_casc_mode
      alt_casc_mode = 1'b1;
      lo_phase_mode = 1'b1;
      wait_n(1);
      {lo_ph_a, lo_ph_b} = 2'b00; wait_n(5);
      {lo_ph_a, lo_ph_b} = 2'b01; wait_n(5);
      {lo_ph_a, lo_ph_b} = 2'b11; wait_n(5);
      {lo_ph_a, lo_ph_b} = 2'b10; wait_n(5);
      check("R5 hold alt mode", count_out, 32'h0000_FFFF);
      alt_casc_mode = 1'b0;
      hi_clk_carry  = 1'b0;
      wait_n(1);
      {lo_ph_a, lo_ph_b} = 2'b11; wait_n(5);
      check("R5 hold no carry src", count_out, 32'h0000_0000);
      hi_clk_carry  = 1'b1;
      hi_phase_mode = 1'b1;
      wait_n(1);
      {lo_ph_a, lo_ph_b} = 2'b10;
      {hi_ph_a, hi_ph_b} = 2'b10;
      wait_n(6);
      check("R5 independent high", count_out, 32'h0001_FFFF);
      hi_phase_mode = 1'b0;
      lo_phase_mode = 1'b0;
      wait_n(2);

      // capture tests, counters idle at 0001_FFFF
      edge_sel = 2'd1;
      set_pin(0, 1'b1);
      check("R8 rise capture count", strb_cnt[0], 1);
      check("R8 capture value", {16'h0, cap_hi_a}, 32'h0001);
      set_pin(0, 1'b0);
      check("R8 no capture on fall", strb_cnt[0], 1);
      set_pin(2, 1'b1);
      check("R6 partner ignored", strb_cnt[0], 1);
      check("R8 low capture value", {16'h0, cap_lo_a}, 32'hFFFF);
      set_pin(2, 1'b0);
      link_en = 4'b0001;
      wait_n(2);
      set_pin(2, 1'b1);
      check("R7 OR trigger", strb_cnt[0], 2);
      check("R6 own pin count", strb_cnt[2], 2);
      set_pin(2, 1'b0);
      set_pin(0, 1'b1);
      check("R7 own edge", strb_cnt[0], 3);
      set_pin(2, 1'b1);
      check("R7 masked by high partner", strb_cnt[0], 3);
      set_pin(2, 1'b0);
      set_pin(0, 1'b0);
      check("R7 masked after release", strb_cnt[0], 3);

      edge_sel = 2'd2;
      wait_n(2);
      set_pin(1, 1'b1);
      check("R8 falling ignores rise", strb_cnt[1], 0);
      set_pin(1, 1'b0);
      check("R8 falling capture", strb_cnt[1], 1);
      check("R8 falling value", {16'h0, cap_hi_b}, 32'h0001);
      edge_sel = 2'd3;
      wait_n(2);
      set_pin(3, 1'b1);
      set_pin(3, 1'b0);
      check("R8 both edges", strb_cnt[3], 2);
      check("R8 both value", {16'h0, cap_lo_b}, 32'hFFFF);
      edge_sel = 2'd0;
      wait_n(2);
      set_pin(0, 1'b1);
      set_pin(0, 1'b0);
      check("R8 none", strb_cnt[0], 3);

      // R9 consistent snapshot
      edge_sel = 2'd1;
      link_en  = 4'b0101;
      wait_n(2);
      pulse_en(2);
      check("R2 carry before snapshot", count_out, 32'h0002_0001);
      set_pin(0, 1'b1);
      check("R9 coincident strobes", coin_cnt, 2);
      check("R9 snapshot", {cap_hi_a, cap_lo_a}, 32'h0002_0001);
      set_pin(0, 1'b0);

      // R10 reset in mid-run
      rst_n = 1'b0;
      wait_n(2);
      check("R10 mid reset count", count_out, 32'h0);
      check("R10 mid reset caps", {cap_hi_a, cap_lo_a}, 32'h0);
      rst_n = 1'b1;
      wait_n(2);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule